// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block turns the two phase signals and the index signal of an incremental encoder into a position count. The count goes up or down and is bounded by a programmable maximum. The encoder inputs arrive asynchronous and are retimed by a two-flop synchronizer. A 16-bit control word then picks one of eight operating codes:

- idle;
- a free-running tick counter;
- two unused codes;
- four decoding variants, which combine half resolution (phase A edges only) or full resolution (every phase edge) with a reset source (the index pulse or the maximum count).

Besides the operating code, the control word sets three things:

- whether the phases are exchanged before decoding;
- whether the direction is driven onto an output pin;
- a sticky flag that marks an index pulse seen at an unexpected count.

Software reaches the control word and the maximum-count register through one select bit on a simple read/write port. The count is always visible on a dedicated output.

Top module: `qenc_pos_if`

## Requirements
- R1: After reset the control word reads 0x0000, the maximum-count register reads all ones, the count is 0, and the direction pin enable is low.
- R2: Control word layout:
  - [15] error flag
  - [12] synchronized index level
  - [11] direction
  - [10:8] operating code
  - [7] phase exchange
  - [6] direction pin enable
  - Bits 14, 13 and 5:0 always read 0, even after a write of 1.
  - Writing 1 to bit 15 never sets the flag.
- R3: With code 110 or 111 (full resolution), every single-phase edge moves the count by one. The (A,B) sequence 00, 10, 11, 01 counts up and the reverse counts down. The count changes on the third rising clock edge after the input change.
- R4: With code 100 or 101 (half resolution), only edges of phase A move the count. The count goes up when A differs from B after the edge, and down otherwise.
- R5: When bit 7 is 1, A and B are exchanged before decoding, so the same input motion counts the opposite way.
- R6: In codes 1xx, bit 11 follows the decoded direction (1 up, 0 down), and software writes to it are ignored.
- R7: In code 001, each clock with the tick enable high moves the count one step. The step is up when bit 11 is 1 and down when it is 0. Bit 11 is loaded from the write data whenever a write selects code 001.
- R8: In codes 000, 010 and 011 the count holds its value whatever the phases do.
- R9: In every counting code:
  - an up step from the maximum gives 0;
  - a down step from 0 gives the maximum.
- R10: In codes 100 and 110, a rising edge of the synchronized index clears the count to 0. This clear wins over a step in the same cycle. In codes 101 and 111 the index has no effect on the count.
- R11: The error flag is set by an index clear in codes 100 or 110 while the count is neither 0 nor the maximum. It stays set until software writes 0 to bit 15. A set in the same cycle wins over the clear.
- R12: The direction pin enable equals bit 6. The direction pin carries bit 11 when enabled and 0 otherwise.
- R13: Bit 12 shows the index input after two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the maximum count |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| idx_in | input | 1 | Encoder index, asynchronous |
| tick_en | input | 1 | Step enable for tick-counter mode |
| dir_out | output | 1 | Direction pin value |
| dir_oe | output | 1 | Direction pin enable |
| pos_cnt | output | 16 | Position count |

## Verification
Two things can fall in the same cycle: an index clear and a phase step. The bench provokes this by changing the index and one phase at the same instant. Both pass through equal synchronizer depth, so they reach the counter together, and the count must read 0 rather than the stepped value. The clear must also raise the error flag, because the count before the clear was 3. A behavioural model with its own Gray-position arithmetic checks count, direction, pin and read data on every clock.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   localparam int REG_W = 16;

   typedef enum logic [2:0] {
      MD_OFF    = 3'b000,
      MD_TICK   = 3'b001,
      MD_NONE2  = 3'b010,
      MD_NONE3  = 3'b011,
      MD_X2_IDX = 3'b100,
      MD_X2_MAX = 3'b101,
      MD_X4_IDX = 3'b110,
      MD_X4_MAX = 3'b111
   } qmode_e;

   // control word bit positions
   localparam int B_ERR  = 15;
   localparam int B_IDX  = 12;
   localparam int B_DIR  = 11;
   localparam int B_MDLO = 8;
   localparam int B_SWP  = 7;
   localparam int B_OE   = 6;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s - 1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic a_in,
   input  logic b_in,
   input  logic swap,
   input  logic quad_en,
   input  logic full_res,
   output logic step,
   output logic up
);
   logic a, b, a_prev, b_prev, chg_a, chg_b;

   assign a = swap ? b_in : a_in;
   assign b = swap ? a_in : b_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
      end else begin
         a_prev <= a;
         b_prev <= b;
      end
   end

   assign chg_a = a ^ a_prev;
   assign chg_b = b ^ b_prev;

   // a lone A edge counts in both resolutions; a lone B edge only at full
   assign step = quad_en & ((chg_a & ~chg_b) | (full_res & chg_b & ~chg_a));
   assign up   = a ^ b_prev;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         up,
   input  logic         clr,
   input  logic [W-1:0] maxv,
   output logic [W-1:0] cnt
);
   logic [W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr)                     cnt_d = '0;
      else if (step && up)         cnt_d = (cnt_q == maxv) ? '0 : cnt_q + 1'b1;
      else if (step)               cnt_d = (cnt_q == '0) ? maxv : cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;

   // R10
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R9
   wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step && up && cnt == maxv) |=> (cnt == '0));
   // R9
   wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step && !up && cnt == '0) |=> (cnt == $past(maxv)));
endmodule

// File: rtl/qenc_pos_if.sv
module qenc_pos_if
   import qenc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             ph_a,
   input  logic             ph_b,
   input  logic             idx_in,
   input  logic             tick_en,
   output logic             dir_out,
   output logic             dir_oe,
   output logic [CNT_W-1:0] pos_cnt
);
   localparam int PAD_W = REG_W - CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_w
         $error("qenc_pos_if: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [2:0]       sync_q;
   logic             a_s, b_s, idx_s, idx_prev;
   qmode_e           mode_q;
   logic             swap_q, oe_q, dir_q, err_q;
   logic [CNT_W-1:0] max_q;
   logic             quad, full_res, idx_mode, tick_mode;
   logic             dec_step, dec_up, step_all, up_all;
   logic             idx_rise, clr, err_hit, wr_ctrl, wr_max;

   qenc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({idx_in, ph_b, ph_a}), .q(sync_q));

   assign {idx_s, b_s, a_s} = sync_q;

   assign quad      = mode_q[2];
   assign full_res  = mode_q[1];
   assign idx_mode  = quad & ~mode_q[0];
   assign tick_mode = (mode_q == MD_TICK);

   qenc_decode u_dec (
      .clk(clk), .rst_n(rst_n), .a_in(a_s), .b_in(b_s), .swap(swap_q),
      .quad_en(quad), .full_res(full_res), .step(dec_step), .up(dec_up));

   assign step_all = quad ? dec_step : (tick_mode & tick_en);
   assign up_all   = quad ? dec_up   : dir_q;
   assign idx_rise = idx_s & ~idx_prev;
   assign clr      = idx_mode & idx_rise;
   assign err_hit  = clr & (pos_cnt != '0) & (pos_cnt != max_q);

   qenc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step_all), .up(up_all), .clr(clr),
      .maxv(max_q), .cnt(pos_cnt));

   assign wr_ctrl = reg_wr & ~reg_sel;
   assign wr_max  = reg_wr &  reg_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MD_OFF;
         swap_q   <= 1'b0;
         oe_q     <= 1'b0;
         dir_q    <= 1'b0;
         err_q    <= 1'b0;
         idx_prev <= 1'b0;
         max_q    <= '1;
      end else begin
         idx_prev <= idx_s;
         if (wr_ctrl) begin
            mode_q <= qmode_e'(reg_wdata[B_MDLO +: 3]);
            swap_q <= reg_wdata[B_SWP];
            oe_q   <= reg_wdata[B_OE];
         end
         if (wr_ctrl && reg_wdata[B_MDLO +: 3] == MD_TICK) dir_q <= reg_wdata[B_DIR];
         else if (dec_step)                                  dir_q <= dec_up;
         err_q <= err_hit | (err_q & ~(wr_ctrl & ~reg_wdata[B_ERR]));
         if (wr_max) max_q <= reg_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         reg_rdata = {{PAD_W{1'b0}}, max_q};
      end else begin
         reg_rdata[B_ERR]         = err_q;
         reg_rdata[B_IDX]         = idx_s;
         reg_rdata[B_DIR]         = dir_q;
         reg_rdata[B_MDLO +: 3]   = mode_q;
         reg_rdata[B_SWP]         = swap_q;
         reg_rdata[B_OE]          = oe_q;
      end
   end

   assign dir_oe  = oe_q;
   assign dir_out = oe_q & dir_q;

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!quad && !tick_mode) |=> $stable(pos_cnt));
   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(wr_ctrl && !reg_wdata[B_ERR])) |=> err_q);
   // R12
   pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_oe |-> !dir_out);
   // R6
   dir_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (quad && !dec_step && !(wr_ctrl && reg_wdata[B_MDLO +: 3] == MD_TICK))
      |=> $stable(dir_q));
endmodule

// File: tb/qenc_pos_if_tb_top.sv
module qenc_pos_if_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0, tick_en = 1'b0;
   logic        dir_out, dir_oe;
   logic [15:0] pos_cnt;

   int n_chk = 0, n_bad = 0;
   int gi = 0;
   bit done = 0;

   always #2 clk = ~clk;

   qenc_pos_if dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ph_a(ph_a), .ph_b(ph_b),
      .idx_in(idx_in), .tick_en(tick_en), .dir_out(dir_out), .dir_oe(dir_oe),
      .pos_cnt(pos_cnt));

   // behavioural model state
   bit m_a1, m_b1, m_i1, m_a2, m_b2, m_i2, m_pa, m_pb, m_ip;
   int m_cnt, m_max, m_mode;
   bit m_swap, m_oe, m_dir, m_err;

   function automatic int gpos(bit a, bit b);
      if (!a && !b) return 0;
      if ( a && !b) return 1;
      if ( a &&  b) return 2;
      return 3;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_a1, m_b1, m_i1, m_a2, m_b2, m_i2, m_pa, m_pb, m_ip} = '0;
         m_cnt = 0; m_max = 16'hFFFF; m_mode = 0;
         m_swap = 0; m_oe = 0; m_dir = 0; m_err = 0;
      end else begin
         bit ca, cb, st, u, rise, clr;
         int d, ncnt;
         ca = m_swap ? m_b2 : m_a2;
         cb = m_swap ? m_a2 : m_b2;
         st = 0; u = 0;
         if (m_mode >= 4) begin
            d = (gpos(ca, cb) - gpos(m_pa, m_pb) + 4) % 4;
            if (m_mode >= 6) st = (d == 1 || d == 3);
            else             st = (ca != m_pa) && (cb == m_pb);
            u = (d == 1);
         end else if (m_mode == 1) begin
            st = tick_en; u = m_dir;
         end
         rise = m_i2 && !m_ip;
         clr  = (m_mode == 4 || m_mode == 6) && rise;
         ncnt = m_cnt;
         if (clr) ncnt = 0;
         else if (st && u)  ncnt = (m_cnt == m_max) ? 0 : (m_cnt + 1) & 16'hFFFF;
         else if (st)       ncnt = (m_cnt == 0) ? m_max : m_cnt - 1;
         if (reg_wr && !reg_sel && !reg_wdata[15]) m_err = 0;
         if (clr && m_cnt != 0 && m_cnt != m_max) m_err = 1;
         if (m_mode >= 4 && st) m_dir = u;
         if (reg_wr && !reg_sel && reg_wdata[10:8] == 3'b001) m_dir = reg_wdata[11];
         if (reg_wr && !reg_sel) begin
            m_mode = int'(reg_wdata[10:8]); m_swap = reg_wdata[7]; m_oe = reg_wdata[6];
         end
         if (reg_wr && reg_sel) m_max = int'(reg_wdata);
         m_cnt = ncnt;
         m_pa = ca; m_pb = cb; m_ip = m_i2;
         m_a2 = m_a1; m_b2 = m_b1; m_i2 = m_i1;
         m_a1 = ph_a; m_b1 = ph_b; m_i1 = idx_in;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [15:0] ectl;
         string tg;
         tg = (m_mode >= 6) ? "R3" : (m_mode >= 4) ? "R4" : (m_mode == 1) ? "R7" : "R8";
         chk(pos_cnt == m_cnt[15:0], tg, pos_cnt, m_cnt);
         ectl = {m_err, 2'b00, m_i2, m_dir, m_mode[2:0], m_swap, m_oe, 6'b0};
         if (reg_sel) chk(reg_rdata == m_max[15:0], "R2", reg_rdata, m_max);
         else         chk(reg_rdata == ectl, "R2", reg_rdata, ectl);
         chk(dir_oe == m_oe && dir_out == (m_oe & m_dir), "R12",
             {dir_oe, dir_out}, {m_oe, m_oe & m_dir});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wreg(input bit sel, input logic [15:0] v);
      @(posedge clk); #1;
      reg_wr = 1; reg_sel = sel; reg_wdata = v;
      @(posedge clk); #1;
      reg_wr = 0; reg_sel = 0;
   endtask

   task automatic qstep(input int dn, input int n);
      for (int k = 0; k < n; k++) begin
         gi = (gi + dn + 4) % 4;
         @(posedge clk); #1;
         ph_a = (gi == 1 || gi == 2);
         ph_b = (gi == 2 || gi == 3);
         idle(4);
      end
   endtask

   task automatic ipulse();
      @(posedge clk); #1; idx_in = 1; idle(4);
      idx_in = 0; idle(4);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      // R1: reset values
      chk(reg_rdata == 16'h0000, "R1", reg_rdata, 16'h0000);
      chk(pos_cnt == 0 && dir_oe == 0, "R1", pos_cnt, 0);
      reg_sel = 1; #1;
      chk(reg_rdata == 16'hFFFF, "R1", reg_rdata, 16'hFFFF);
      reg_sel = 0;

      wreg(1, 16'd9);
      wreg(0, 16'h0700);
      qstep(1, 8);
      chk(pos_cnt == 8, "R3", pos_cnt, 8);
      chk(reg_rdata[11] == 1'b1, "R6", reg_rdata[11], 1);
      qstep(1, 2);
      chk(pos_cnt == 0, "R9", pos_cnt, 0);
      qstep(-1, 1);
      chk(pos_cnt == 9, "R9", pos_cnt, 9);
      wreg(0, 16'h4F00);
      idle(1);
      chk(reg_rdata == 16'h0700, "R2", reg_rdata, 16'h0700);
      chk(reg_rdata[11] == 1'b0, "R6", reg_rdata[11], 0);

      wreg(0, 16'h0780);
      qstep(1, 4);
      chk(pos_cnt == 5, "R5", pos_cnt, 5);

      wreg(0, 16'h0500);
      qstep(1, 4);
      chk(pos_cnt == 7, "R4", pos_cnt, 7);
      wreg(0, 16'h0540);
      idle(1);
      chk(dir_oe == 1 && dir_out == 1, "R12", {dir_oe, dir_out}, 2'b11);

      wreg(0, 16'h0900);
      @(posedge clk); #1; tick_en = 1; idle(5); tick_en = 0; idle(2);
      chk(pos_cnt == 2, "R7", pos_cnt, 2);
      wreg(0, 16'h0100);
      @(posedge clk); #1; tick_en = 1; idle(3); tick_en = 0; idle(2);
      chk(pos_cnt == 9, "R7", pos_cnt, 9);

      wreg(0, 16'h0000);
      qstep(1, 4);
      chk(pos_cnt == 9, "R8", pos_cnt, 9);
      wreg(0, 16'h0200);
      qstep(-1, 3);
      chk(pos_cnt == 9, "R8", pos_cnt, 9);
      qstep(1, 3);

      wreg(0, 16'h0600);
      qstep(1, 2);
      chk(pos_cnt == 1, "R3", pos_cnt, 1);
      @(posedge clk); #1; idx_in = 1; idle(4);
      chk(reg_rdata[12] == 1'b1, "R13", reg_rdata[12], 1);
      chk(pos_cnt == 0, "R10", pos_cnt, 0);
      chk(reg_rdata[15] == 1'b1, "R11", reg_rdata[15], 1);
      idx_in = 0; idle(4);
      chk(reg_rdata[12] == 1'b0, "R13", reg_rdata[12], 0);
      wreg(0, 16'h8600);
      idle(1);
      chk(reg_rdata[15] == 1'b1, "R11", reg_rdata[15], 1);
      wreg(0, 16'h0600);
      idle(1);
      chk(reg_rdata[15] == 1'b0, "R11", reg_rdata[15], 0);
      ipulse();
      chk(reg_rdata[15] == 1'b0, "R11", reg_rdata[15], 0);

      wreg(0, 16'h0700);
      qstep(1, 3);
      ipulse();
      chk(pos_cnt == 3, "R10", pos_cnt, 3);

      // index clear and phase step in the same cycle
      wreg(0, 16'h0600);
      gi = (gi + 1) % 4;
      @(posedge clk); #1;
      ph_a = (gi == 1 || gi == 2);
      ph_b = (gi == 2 || gi == 3);
      idx_in = 1;
      idle(4);
      chk(pos_cnt == 0, "R10", pos_cnt, 0);
      chk(reg_rdata[15] == 1'b1, "R11", reg_rdata[15], 1);
      idx_in = 0; idle(4);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule